// File: doc/BRIEF.md
# Debug Breakpoint Status and Control Register

This block is the 32-bit configuration and status word of a processor debug unit. It holds a small two-level hardware breakpoint sequencer. Writing the trigger definition arms the sequencer. A level-1 match then either finishes the sequence or, when level 2 is enabled, arms level 2. A later level-2 match finishes the sequence. The block also keeps sticky flags that record why the core entered debug mode.

The word carries three host-controlled mode bits. The write-inhibit bit blocks processor writes to the debug registers, and only the external debug host can change it. The address-map bit and the trace-to-emulator bit drive the core's emulator-mode behaviour. The word is read combinationally, so a read returns the value held before that cycle's update. A read strobe clears the sticky flags and, when the sequence has finished, the breakpoint status.

Top module: `dbg_csr_top`

## Requirements
- R1: After reset the whole word reads zero, `cpu_wr_ok_o` is 1, and `map_o` and `trc_o` are 0.
- R2: A trigger-definition write with level 1 enabled sets status to 0001. With level 1 disabled it sets status to 0000. With only level 1 armed, a level-1 match moves status from 0001 to 0010.
- R3: With level 2 also enabled at arming, a level-1 match moves 0001 to 0101, and a level-2 match then moves 0101 to 0110. A level-2 match in 0001 is ignored, and so is a level-1 match in 0000.
- R4: A read clears status to 0000 only when status is 0010 or 0110. A read in 0001 or 0101 leaves status unchanged.
- R5: A trigger-definition write re-arms status from any state. It takes precedence over a same-cycle read clear.
- R6: The fault-on-fault flag (bit 27) is set by a catastrophic-halt event. It is cleared by a read, and the resume command leaves it unchanged.
- R7: The breakpoint-trigger (bit 26), halt (bit 25) and external-breakpoint (bit 24) flags are each set by their own event. Each is cleared by a read or by the resume command.
- R8: A set event in the same cycle as a clearing read or resume leaves the flag set. The read value in that cycle shows the flag as it was before the event.
- R9: The write-inhibit bit (bit 16) is written only by host writes. While it is 1, processor writes change nothing and `cpu_wr_ok_o` is 0.
- R10: Bits 15 (map) and 14 (trace-to-emulator) take the written data on a host write, or on an allowed processor write. When both writes occur in the same cycle, the host write wins. `map_o` and `trc_o` follow these bits.
- R11: The revision field (bits 23:20) reads 0000. Bits 19:17 and 13:0 read zero, and writes to them are ignored.
- R12: The word layout is status[31:28], fault-on-fault[27], trigger[26], halt[25], external breakpoint[24], revision[23:20], zero[19:17], inhibit[16], map[15], trace[14], zero[13:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdef_we_i | input | 1 | Trigger-definition write strobe |
| tdef_l1_en_i | input | 1 | Level-1 enable carried with the trigger write |
| tdef_l2_en_i | input | 1 | Level-2 enable carried with the trigger write |
| l1_hit_i | input | 1 | Level-1 match pulse |
| l2_hit_i | input | 1 | Level-2 match pulse |
| fof_evt_i | input | 1 | Catastrophic-halt debug entry |
| trg_evt_i | input | 1 | Hardware-breakpoint debug entry |
| halt_evt_i | input | 1 | Halt-instruction debug entry |
| bkpt_evt_i | input | 1 | External breakpoint-pin debug entry |
| go_i | input | 1 | Resume command strobe |
| rd_i | input | 1 | Register read strobe |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | 32 | Processor write data |
| host_we_i | input | 1 | Debug-host write strobe |
| host_wdata_i | input | 32 | Debug-host write data |
| rdata_o | output | 32 | Register read value |
| cpu_wr_ok_o | output | 1 | Processor writes to debug registers allowed |
| map_o | output | 1 | Emulator references to special space |
| trc_o | output | 1 | Trace exception enters emulator mode |

## Verification
The bench targets the conditional read clear. A design that clears on every read would lose the waiting states 0001 and 0101. It also targets arming while a read is pending, where a design that lets the read win would show 0000 instead of the re-armed code. Stray match pulses in the wrong state are driven to catch a sequencer that skips level 1 or finishes early. Same-cycle set and clear collisions, resume against fault-on-fault, and processor attempts to clear the inhibit bit expose flags that drop events, resume wrongly clearing bit 27, or a processor that can unlock itself.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned ST_W      = 4;
  localparam int unsigned N_GO_FLAG = 3;  // trg, halt, bkpt
  localparam int unsigned B_ST_LO   = 28;
  localparam int unsigned B_FOF     = 27;
  localparam int unsigned B_TRG     = 26;
  localparam int unsigned B_HALT    = 25;
  localparam int unsigned B_BKPT    = 24;
  localparam int unsigned B_REV_LO  = 20;
  localparam int unsigned B_IPW     = 16;
  localparam int unsigned B_MAP     = 15;
  localparam int unsigned B_TRC     = 14;

  typedef enum logic [ST_W-1:0] {
    ST_OFF   = 4'b0000,
    ST_WAIT1 = 4'b0001,
    ST_HIT1  = 4'b0010,
    ST_WAIT2 = 4'b0101,
    ST_HIT2  = 4'b0110
  } bkpt_st_e;
endpackage

// File: rtl/dbg_bkpt_seq.sv
module dbg_bkpt_seq
  import dbg_csr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tdef_we_i,
  input  logic     l1_en_i,
  input  logic     l2_en_i,
  input  logic     l1_hit_i,
  input  logic     l2_hit_i,
  input  logic     rd_i,
  output bkpt_st_e st_o
);
  bkpt_st_e st_q, st_d;
  logic     l2_arm_q;

  always_comb begin
    st_d = st_q;
    if (tdef_we_i) begin
      st_d = l1_en_i ? ST_WAIT1 : ST_OFF;
    end else begin
      unique case (st_q)
        ST_WAIT1: if (l1_hit_i) st_d = l2_arm_q ? ST_WAIT2 : ST_HIT1;
        ST_WAIT2: if (l2_hit_i) st_d = ST_HIT2;
        ST_HIT1, ST_HIT2: if (rd_i) st_d = ST_OFF;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      l2_arm_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (tdef_we_i) l2_arm_q <= l1_en_i & l2_en_i;
    end
  end

  assign st_o = st_q;

  AST_RD_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tdef_we_i && rd_i && (st_q == ST_HIT1 || st_q == ST_HIT2)) |=> st_q == ST_OFF); // R4
  AST_RD_KEEP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tdef_we_i && rd_i && st_q == ST_WAIT2 && !l2_hit_i) |=> st_q == ST_WAIT2); // R4
  AST_L2_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tdef_we_i && st_q == ST_WAIT2 && l2_hit_i) |=> st_q == ST_HIT2); // R3
  AST_ARM_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdef_we_i && l1_en_i) |=> st_q == ST_WAIT1); // R5
endmodule

// File: rtl/dbg_cause_flags.sv
module dbg_cause_flags
  import dbg_csr_pkg::*;
#(
  parameter int unsigned N_FLAG = N_GO_FLAG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fof_evt_i,
  input  logic [N_FLAG-1:0] evt_i,
  input  logic              go_i,
  input  logic              rd_i,
  output logic              fof_o,
  output logic [N_FLAG-1:0] flag_o
);
  logic fof_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fof_q <= 1'b0;
    else if (fof_evt_i) fof_q <= 1'b1;
    else if (rd_i)      fof_q <= 1'b0;
  end
  assign fof_o = fof_q;

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            f_q <= 1'b0;
      else if (evt_i[g])      f_q <= 1'b1;
      else if (rd_i || go_i)  f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> f_q); // R8
    AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[g] && (rd_i || go_i)) |=> !f_q); // R7
  end

  AST_FOF_GO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fof_q && go_i && !rd_i) |=> fof_q); // R6
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [CSR_W-1:0] cpu_wdata_i,
  input  logic             host_we_i,
  input  logic [CSR_W-1:0] host_wdata_i,
  output logic             ipw_o,
  output logic             map_o,
  output logic             trc_o
);
  logic ipw_q, map_q, trc_q;
  logic cpu_ok;

  assign cpu_ok = cpu_we_i & ~ipw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipw_q <= 1'b0;
      map_q <= 1'b0;
      trc_q <= 1'b0;
    end else if (host_we_i) begin
      ipw_q <= host_wdata_i[B_IPW];
      map_q <= host_wdata_i[B_MAP];
      trc_q <= host_wdata_i[B_TRC];
    end else if (cpu_ok) begin
      map_q <= cpu_wdata_i[B_MAP];
      trc_q <= cpu_wdata_i[B_TRC];
    end
  end

  assign ipw_o = ipw_q;
  assign map_o = map_q;
  assign trc_o = trc_q;

  AST_IPW_HOST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i |=> $stable(ipw_q)); // R9
  AST_IPW_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipw_q && !host_we_i) |=> ($stable(map_q) && $stable(trc_q))); // R9
  AST_HOST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> (map_q == $past(host_wdata_i[B_MAP]))); // R10
endmodule

// File: rtl/dbg_csr_top.sv
module dbg_csr_top
  import dbg_csr_pkg::*;
#(
  parameter logic [3:0] REV_LEVEL = 4'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tdef_we_i,
  input  logic             tdef_l1_en_i,
  input  logic             tdef_l2_en_i,
  input  logic             l1_hit_i,
  input  logic             l2_hit_i,
  input  logic             fof_evt_i,
  input  logic             trg_evt_i,
  input  logic             halt_evt_i,
  input  logic             bkpt_evt_i,
  input  logic             go_i,
  input  logic             rd_i,
  input  logic             cpu_we_i,
  input  logic [CSR_W-1:0] cpu_wdata_i,
  input  logic             host_we_i,
  input  logic [CSR_W-1:0] host_wdata_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic             cpu_wr_ok_o,
  output logic             map_o,
  output logic             trc_o
);
  bkpt_st_e             st;
  logic                 fof;
  logic [N_GO_FLAG-1:0] flags;
  logic                 ipw, map_b, trc_b;

  dbg_bkpt_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tdef_we_i (tdef_we_i),
    .l1_en_i   (tdef_l1_en_i),
    .l2_en_i   (tdef_l2_en_i),
    .l1_hit_i  (l1_hit_i),
    .l2_hit_i  (l2_hit_i),
    .rd_i      (rd_i),
    .st_o      (st)
  );

  // flag order: [2]=trg [1]=halt [0]=bkpt, matches bits 26..24
  dbg_cause_flags #(.N_FLAG(N_GO_FLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fof_evt_i (fof_evt_i),
    .evt_i     ({trg_evt_i, halt_evt_i, bkpt_evt_i}),
    .go_i      (go_i),
    .rd_i      (rd_i),
    .fof_o     (fof),
    .flag_o    (flags)
  );

  dbg_mode_ctrl u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_we_i     (cpu_we_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .host_we_i    (host_we_i),
    .host_wdata_i (host_wdata_i),
    .ipw_o        (ipw),
    .map_o        (map_b),
    .trc_o        (trc_b)
  );

  always_comb begin
    rdata_o                              = '0;
    rdata_o[B_ST_LO +: ST_W]             = st;
    rdata_o[B_FOF]                       = fof;
    rdata_o[B_BKPT +: N_GO_FLAG]         = flags;
    rdata_o[B_REV_LO +: 4]               = REV_LEVEL;
    rdata_o[B_IPW]                       = ipw;
    rdata_o[B_MAP]                       = map_b;
    rdata_o[B_TRC]                       = trc_b;
  end

  assign cpu_wr_ok_o = ~ipw;
  assign map_o       = map_b;
  assign trc_o       = trc_b;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[19:17] == 3'b0) && (rdata_o[13:0] == 14'b0)); // R11
endmodule

// File: tb/dbg_csr_top_tb_top.sv
module dbg_csr_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tdef_we = 0, l1_en = 0, l2_en = 0, l1_hit = 0, l2_hit = 0;
  logic fof_evt = 0, trg_evt = 0, halt_evt = 0, bkpt_evt = 0;
  logic go = 0, rd = 0, cpu_we = 0, host_we = 0;
  logic [31:0] cpu_wd = '0, host_wd = '0;
  logic [31:0] rdata;
  logic cpu_ok, map, trc;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  int m_st = 0;
  bit m_l2arm = 0, m_fof = 0, m_trg = 0, m_halt = 0, m_bkpt = 0;
  bit m_ipw = 0, m_map = 0, m_trc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_csr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tdef_we_i(tdef_we), .tdef_l1_en_i(l1_en), .tdef_l2_en_i(l2_en),
    .l1_hit_i(l1_hit), .l2_hit_i(l2_hit),
    .fof_evt_i(fof_evt), .trg_evt_i(trg_evt), .halt_evt_i(halt_evt), .bkpt_evt_i(bkpt_evt),
    .go_i(go), .rd_i(rd),
    .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wd),
    .host_we_i(host_we), .host_wdata_i(host_wd),
    .rdata_o(rdata), .cpu_wr_ok_o(cpu_ok), .map_o(map), .trc_o(trc)
  );

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    w[31:28] = m_st[3:0];
    w[27] = m_fof; w[26] = m_trg; w[25] = m_halt; w[24] = m_bkpt;
    w[16] = m_ipw; w[15] = m_map; w[14] = m_trc;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nst = m_st;
    if (tdef_we) begin
      nst = l1_en ? 1 : 0;
      m_l2arm = l1_en && l2_en;
    end else if (m_st == 1 && l1_hit) nst = m_l2arm ? 5 : 2;
    else if (m_st == 5 && l2_hit) nst = 6;
    else if (rd && (m_st == 2 || m_st == 6)) nst = 0;
    m_st = nst;
    if (fof_evt) m_fof = 1; else if (rd) m_fof = 0;
    if (trg_evt) m_trg = 1; else if (rd || go) m_trg = 0;
    if (halt_evt) m_halt = 1; else if (rd || go) m_halt = 0;
    if (bkpt_evt) m_bkpt = 1; else if (rd || go) m_bkpt = 0;
    if (host_we) begin
      m_ipw = host_wd[16]; m_map = host_wd[15]; m_trc = host_wd[14];
    end else if (cpu_we && !m_ipw) begin
      m_map = cpu_wd[15]; m_trc = cpu_wd[14];
    end
  endtask

  // every-clock comparison of the full word and side outputs
  task automatic compare_all();
    check("R12 word", rdata, m_word());
    check("R9 cpu_wr_ok", {31'b0, cpu_ok}, {31'b0, !m_ipw});
    check("R10 map_o", {31'b0, map}, {31'b0, m_map});
    check("R10 trc_o", {31'b0, trc}, {31'b0, m_trc});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    tdef_we = 0; l1_en = 0; l2_en = 0; l1_hit = 0; l2_hit = 0;
    fof_evt = 0; trg_evt = 0; halt_evt = 0; bkpt_evt = 0;
    go = 0; rd = 0; cpu_we = 0; host_we = 0; cpu_wd = '0; host_wd = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", rdata, 32'h0);
    check("R1 reset cpu_ok", {31'b0, cpu_ok}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 level-1 only
    tdef_we = 1; l1_en = 1; cyc();
    check("R2 armed", {28'b0, rdata[31:28]}, 32'h1);
    l2_hit = 1; cyc();
    check("R3 l2 hit ignored in 0001", {28'b0, rdata[31:28]}, 32'h1);
    rd = 1; cyc();
    check("R4 read keeps 0001", {28'b0, rdata[31:28]}, 32'h1);
    l1_hit = 1; cyc();
    check("R2 l1 hit", {28'b0, rdata[31:28]}, 32'h2);
    rd = 1; cyc();
    check("R4 read clears 0010", {28'b0, rdata[31:28]}, 32'h0);
    l1_hit = 1; cyc();
    check("R3 l1 hit ignored in 0000", {28'b0, rdata[31:28]}, 32'h0);
    tdef_we = 1; l1_en = 0; l2_en = 1; cyc();
    check("R2 l1 disabled", {28'b0, rdata[31:28]}, 32'h0);

    // R3 two-level
    tdef_we = 1; l1_en = 1; l2_en = 1; cyc();
    l2_hit = 1; cyc();
    check("R3 l2 before l1 ignored", {28'b0, rdata[31:28]}, 32'h1);
    l1_hit = 1; cyc();
    check("R3 wait l2", {28'b0, rdata[31:28]}, 32'h5);
    rd = 1; cyc();
    check("R4 read keeps 0101", {28'b0, rdata[31:28]}, 32'h5);
    l2_hit = 1; cyc();
    check("R3 l2 hit", {28'b0, rdata[31:28]}, 32'h6);
    tdef_we = 1; l1_en = 1; rd = 1; cyc();
    check("R5 arm beats read", {28'b0, rdata[31:28]}, 32'h1);
    l1_hit = 1; cyc();
    check("R5 rearmed level-1 only", {28'b0, rdata[31:28]}, 32'h2);
    tdef_we = 1; cyc();
    check("R5 write clears done", {28'b0, rdata[31:28]}, 32'h0);

    // R6 fault-on-fault
    fof_evt = 1; cyc();
    check("R6 fof set", {31'b0, rdata[27]}, 32'h1);
    go = 1; cyc();
    check("R6 go keeps fof", {31'b0, rdata[27]}, 32'h1);
    rd = 1; cyc();
    check("R6 read clears fof", {31'b0, rdata[27]}, 32'h0);

    // R7 go-clearable flags
    trg_evt = 1; halt_evt = 1; bkpt_evt = 1; cyc();
    check("R7 flags set", {29'b0, rdata[26:24]}, 32'h7);
    go = 1; cyc();
    check("R7 go clears", {29'b0, rdata[26:24]}, 32'h0);
    halt_evt = 1; cyc();
    check("R7 halt only", {29'b0, rdata[26:24]}, 32'h2);
    rd = 1; cyc();
    check("R7 read clears", {29'b0, rdata[26:24]}, 32'h0);

    // R8 set beats clear, read shows pre-update
    trg_evt = 1; fof_evt = 1; rd = 1; go = 1;
    #1 check("R8 pre-update read", {28'b0, rdata[27:24]}, 32'h0);
    cyc();
    check("R8 set wins", {28'b0, rdata[27:24]}, 32'hC);
    rd = 1; cyc();

    // R10 / R9 writes
    cpu_we = 1; cpu_wd = 32'h0001_C000; cyc();
    check("R9 cpu cannot set ipw", {31'b0, rdata[16]}, 32'h0);
    check("R10 cpu writes map/trc", {30'b0, rdata[15:14]}, 32'h3);
    host_we = 1; host_wd = 32'h0001_0000; cyc();
    check("R9 host sets ipw", {31'b0, cpu_ok}, 32'h0);
    cpu_we = 1; cpu_wd = 32'h0000_C000; cyc();
    check("R9 cpu write blocked", {29'b0, rdata[16:14]}, 32'h4);
    host_we = 1; host_wd = 32'h0000_8000; cpu_we = 1; cpu_wd = 32'h0001_4000; cyc();
    check("R10 host wins", {29'b0, rdata[16:14]}, 32'h2);
    check("R10 map_o", {30'b0, map, trc}, 32'h2);

    // R11 reserved and revision
    host_we = 1; host_wd = 32'hFFFF_FFFF; cyc();
    check("R11 rev/reserved", {18'b0, rdata[23:17], 7'b0} | {18'b0, rdata[13:0]}, 32'h0);
    check("R11 writable bits", {29'b0, rdata[16:14]}, 32'h7);

    // R1 async reset mid-run
    fof_evt = 1; trg_evt = 1; tdef_we = 1; l1_en = 1; cyc();
    rst_n = 0; #1;
    m_st = 0; m_l2arm = 0; m_fof = 0; m_trg = 0; m_halt = 0; m_bkpt = 0;
    m_ipw = 0; m_map = 0; m_trc = 0;
    check("R1 reset clears", rdata, 32'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    compare_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule